// File: doc/BRIEF.md
# PSRAM Request Controller with Power-Up Sequencing

This block stands between a simple memory request port and a counted byte-shift engine that drives a serial pseudo-static RAM. After reset it runs a fixed start-up sequence on its own. It sends a reset-enable command, waits 50 µs, sends a reset command and waits 100 µs. In quad mode it then sends an enter-quad command. Only after that does it accept requests. Each request is turned into one command frame. The frame opens with two header bytes: the number of units to transmit, then the number of units to receive. A unit is a bit in single-line mode and a nibble in quad mode. The opcode, the 24-bit address and any data follow the header.

The request port and both byte streams use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only when the block is idle. The request fields must stay stable while `req_valid` waits for `req_ready`. On the transmit stream, the engine may hold `tx_ready` low for any number of cycles. The block then keeps `tx_valid` and `tx_byte` unchanged. On the receive stream, the engine offers bytes with `rx_valid`. The block raises `rx_ready` only while it is still waiting for read bytes. The read result is held on `rsp_valid`/`rsp_data` until `rsp_ready` takes it.

Parameter `QUAD` selects the line mode. `CLK_HZ` converts the microsecond waits into clock cycles.

Top module: `psram_req_ctrl`

## Requirements
- R1: After reset, `req_ready` and `init_done` are 0. The first frame sent is the reset-enable command 0x66. In single mode it is the three bytes 8, 0, 0x66.
- R2: After the last byte of the reset-enable frame is accepted, no byte is offered for at least 50 µs of clock cycles, and the reset frame 0x99 follows within 8 further cycles. After the reset frame, the block waits at least 100 µs before the next frame in quad mode, or before `req_ready` rises in single mode.
- R3: In quad mode the enter-quad command 0x35 is sent after the second wait. In single mode it is not sent. In both modes `init_done` and `req_ready` rise only once the start-up frames are complete.
- R4: In quad mode a command frame is 8, 0 and then four bytes. The four bytes take command bit pairs from MSB down. In each byte, the first bit of the pair sits at bit 4 and the second at bit 0, and all other bits are 0. So 0x66 becomes 0x01,0x10,0x01,0x10; 0x99 becomes 0x10,0x01,0x10,0x01; and 0x35 becomes 0x00,0x11,0x01,0x01.
- R5: A write of n bytes sends these bytes in order:
  - the transmit count, 8·(4+n) in single mode or 2·(4+n) in quad mode;
  - 0;
  - the opcode, 0x02 in single mode or 0x38 in quad mode;
  - the address, high byte first;
  - n data bytes from `req_wdata`, least significant byte first.
- R6: A read of n bytes sends these bytes in order:
  - the transmit count, 40 in single mode or 10 in quad mode;
  - the receive count, 8·n in single mode or 2·n in quad mode;
  - the opcode, 0x0B in single mode or 0xEB in quad mode;
  - the address, high byte first;
  - one 0xFF dummy byte.
- R7: A read completes only after n bytes have been received. `rsp_data` holds the k-th received byte at bits [8k+7:8k], and all bits above byte n-1 are 0. `rsp_valid` and `rsp_data` stay stable until `rsp_ready` is seen.
- R8: `req_ready` is 0 from acceptance until the last byte of a write frame is accepted, or until a read response is taken.
- R9: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_byte` keeps its value on the next cycle.
- R10: A `req_len` of 0 is treated as 1, and values above 8 are treated as 8, in both the header and the data.
- R11: `rx_ready` is 1 only after a read frame has been fully sent and fewer than n bytes have been received. Receive bytes offered at any other time are not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_len | input | 4 | Byte count, 1 to 8 |
| req_wdata | input | 64 | Write data, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | Read result available |
| rsp_ready | input | 1 | Read result taken |
| rsp_data | output | 64 | Read result, first received byte in bits 7:0 |
| tx_valid | output | 1 | Frame byte offered to the shift engine |
| tx_ready | input | 1 | Shift engine takes the frame byte |
| tx_byte | output | 8 | Frame byte |
| rx_valid | input | 1 | Received byte offered by the shift engine |
| rx_ready | output | 1 | Block takes the received byte |
| rx_byte | input | 8 | Received byte |
| init_done | output | 1 | Start-up sequence complete |

## Verification
The bench runs one quad instance and one single-line instance together. It throttles both byte streams throughout the run.

It measures each start-up wait in cycles. A timer loaded one cycle short, or a single-mode design that opens the request port before the 100 µs wait ends, shows up as a gap outside the allowed window. Each frame byte is compared with an expected queue. This catches a swapped address or data byte order, a wrong header scale between bits and nibbles, a wrong quad bit spread, or an enter-quad frame sent in single mode.

Reads are checked at 1, 2, 3, 4 and 8 bytes while the receive stream keeps offering bytes. A design that stops one byte early, consumes a surplus byte, or leaves stale upper bytes in the result is reported. Writes with out-of-range counts check the clamping.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  typedef enum logic [1:0] {FR_CMD, FR_WRITE, FR_READ} frame_kind_e;

  typedef enum logic [2:0] {
    ST_LOAD_CMD, ST_SEND_CMD, ST_WAIT, ST_IDLE, ST_SEND_REQ, ST_RECV, ST_RESP
  } ctrl_state_e;

  localparam logic [7:0] OP_WR_QUAD  = 8'h38;
  localparam logic [7:0] OP_WR_SGL   = 8'h02;
  localparam logic [7:0] OP_RD_QUAD  = 8'hEB;
  localparam logic [7:0] OP_RD_SGL   = 8'h0B;
  localparam logic [7:0] CMD_RST_EN  = 8'h66;
  localparam logic [7:0] CMD_RST     = 8'h99;
  localparam logic [7:0] CMD_QUAD_ON = 8'h35;

  // Spread bit pair k (MSB first) of a command onto bits 4 and 0 of one byte.
  function automatic logic [7:0] quad_spread(input logic [7:0] c, input int k);
    return {3'b000, c[7-2*k], 3'b000, c[6-2*k]};
  endfunction

endpackage

// File: rtl/psram_frame_build.sv
module psram_frame_build
  import psram_ctrl_pkg::*;
#(
  parameter bit QUAD      = 1'b1,
  parameter int MAX_BYTES = 8,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int FB       = 6 + MAX_BYTES,
  localparam int FLEN_W   = $clog2(FB + 1)
) (
  input  frame_kind_e              kind,
  input  logic [7:0]               cmd,
  input  logic [23:0]              addr,
  input  logic [8*MAX_BYTES-1:0]   wdata,
  input  logic [LEN_W-1:0]         nbytes,
  output logic [8*FB-1:0]          frame,
  output logic [FLEN_W-1:0]        flen
);
  localparam int UNIT = QUAD ? 2 : 8;

  always_comb begin
    frame = '0;
    flen  = '0;
    case (kind)
      FR_CMD: begin
        frame[7:0] = 8'd8;
        if (QUAD) begin
          for (int k = 0; k < 4; k++) frame[8*(2+k) +: 8] = quad_spread(cmd, k);
          flen = FLEN_W'(6);
        end else begin
          frame[23:16] = cmd;
          flen = FLEN_W'(3);
        end
      end
      FR_WRITE: begin
        frame[7:0]   = 8'((32'(nbytes) + 4) * UNIT);
        frame[23:16] = QUAD ? OP_WR_QUAD : OP_WR_SGL;
        frame[31:24] = addr[23:16];
        frame[39:32] = addr[15:8];
        frame[47:40] = addr[7:0];
        for (int i = 0; i < MAX_BYTES; i++)
          if (i < 32'(nbytes)) frame[8*(6+i) +: 8] = wdata[8*i +: 8];
        flen = FLEN_W'(6 + 32'(nbytes));
      end
      FR_READ: begin
        frame[7:0]   = 8'(5 * UNIT);
        frame[15:8]  = 8'(32'(nbytes) * UNIT);
        frame[23:16] = QUAD ? OP_RD_QUAD : OP_RD_SGL;
        frame[31:24] = addr[23:16];
        frame[39:32] = addr[15:8];
        frame[47:40] = addr[7:0];
        frame[55:48] = 8'hFF;
        flen = FLEN_W'(7);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/psram_frame_shift.sv
module psram_frame_shift #(
  parameter int FB     = 14,
  localparam int FLEN_W = $clog2(FB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [8*FB-1:0]   frame_in,
  input  logic [FLEN_W-1:0] len_in,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_byte,
  output logic              last_hs
);
  logic [8*FB-1:0]   fbuf;
  logic [FLEN_W-1:0] flen;
  logic [FLEN_W-1:0] idx;
  logic              busy;

  assign tx_valid = busy;
  assign tx_byte  = fbuf[8*idx +: 8];
  assign last_hs  = busy && tx_ready && (idx == flen - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fbuf <= '0;
      flen <= '0;
      idx  <= '0;
      busy <= 1'b0;
    end else if (load && !busy) begin
      fbuf <= frame_in;
      flen <= len_in;
      idx  <= '0;
      busy <= 1'b1;
    end else if (busy && tx_ready) begin
      idx <= idx + 1'b1;
      if (last_hs) busy <= 1'b0;
    end
  end

  // R9: an offered byte is held while the engine stalls
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));
endmodule

// File: rtl/psram_wait_timer.sv
module psram_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= load_val;
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/psram_req_ctrl.sv
module psram_req_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter bit QUAD          = 1'b1,
  parameter int CLK_HZ        = 100_000_000,
  parameter int RSTEN_WAIT_US = 50,
  parameter int RST_WAIT_US   = 100,
  parameter int MAX_BYTES     = 8,
  localparam int LEN_W  = $clog2(MAX_BYTES + 1),
  localparam int DW     = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [23:0]       req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_byte,
  output logic              init_done
);
  localparam int CYC_US = CLK_HZ / 1_000_000;
  localparam int W_EN   = CYC_US * RSTEN_WAIT_US;
  localparam int W_RST  = CYC_US * RST_WAIT_US;
  localparam int TW     = $clog2((W_EN > W_RST ? W_EN : W_RST) + 1);
  localparam int FB     = 6 + MAX_BYTES;
  localparam int FLEN_W = $clog2(FB + 1);

  ctrl_state_e       state;
  logic [1:0]        step;
  logic [LEN_W-1:0]  cur_len, rx_cnt, n_clamp;
  logic              cur_write;
  frame_kind_e       kind;
  logic [7:0]        cmd;
  logic [8*FB-1:0]   frame;
  logic [FLEN_W-1:0] flen;
  logic              load, last_hs, t_load, t_zero;
  logic [TW-1:0]     t_val;

  assign n_clamp = (req_len == '0) ? LEN_W'(1) :
                   (req_len > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : req_len;
  assign kind = (state == ST_LOAD_CMD) ? FR_CMD : (req_write ? FR_WRITE : FR_READ);
  assign cmd  = (step == 2'd0) ? CMD_RST_EN : (step == 2'd1) ? CMD_RST : CMD_QUAD_ON;

  assign req_ready = (state == ST_IDLE);
  assign rx_ready  = (state == ST_RECV);
  assign rsp_valid = (state == ST_RESP);
  assign load      = (state == ST_LOAD_CMD) || (req_valid && req_ready);
  assign t_load    = (state == ST_SEND_CMD) && last_hs && (step != 2'd2);
  assign t_val     = (step == 2'd0) ? TW'(W_EN) : TW'(W_RST);

  psram_frame_build #(.QUAD(QUAD), .MAX_BYTES(MAX_BYTES)) u_build (
    .kind(kind), .cmd(cmd), .addr(req_addr), .wdata(req_wdata),
    .nbytes(n_clamp), .frame(frame), .flen(flen));

  psram_frame_shift #(.FB(FB)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .frame_in(frame), .len_in(flen),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte), .last_hs(last_hs));

  psram_wait_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_LOAD_CMD;
      step      <= 2'd0;
      cur_len   <= '0;
      cur_write <= 1'b0;
      rx_cnt    <= '0;
      rsp_data  <= '0;
      init_done <= 1'b0;
    end else begin
      case (state)
        ST_LOAD_CMD: state <= ST_SEND_CMD;
        ST_SEND_CMD: if (last_hs) begin
          if (step == 2'd2) begin
            state     <= ST_IDLE;
            init_done <= 1'b1;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: if (t_zero) begin
          if (step == 2'd0) begin
            step  <= 2'd1;
            state <= ST_LOAD_CMD;
          end else if (QUAD) begin
            step  <= 2'd2;
            state <= ST_LOAD_CMD;
          end else begin
            state     <= ST_IDLE;
            init_done <= 1'b1;
          end
        end
        ST_IDLE: if (req_valid) begin
          cur_len   <= n_clamp;
          cur_write <= req_write;
          rsp_data  <= '0;
          state     <= ST_SEND_REQ;
        end
        ST_SEND_REQ: if (last_hs) begin
          rx_cnt <= '0;
          state  <= cur_write ? ST_IDLE : ST_RECV;
        end
        ST_RECV: if (rx_valid) begin
          rsp_data[8*rx_cnt +: 8] <= rx_byte;
          rx_cnt <= rx_cnt + 1'b1;
          if (rx_cnt == cur_len - 1'b1) state <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: the request port opens only after start-up has finished
  a_r3_ready_after_init: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> init_done);
  // R8: no acceptance while a frame is still being shifted
  a_r8_idle_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !tx_valid);
  // R7: a pending result is held until taken
  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R11: receive bytes are taken only after the read frame is out
  a_r11_rx_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (!tx_valid && !req_ready));
  // R2: nothing is offered while a start-up wait is running
  a_r2_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> (!tx_valid && !t_load));
endmodule

// File: tb/sim_psram_req_ctrl.sv
module sim_lane #(
  parameter bit QUAD = 1'b1
) (
  input  logic clk,
  output int   errs,
  output int   checks,
  output logic done
);
  localparam int LEN0 = QUAD ? 6 : 3;
  localparam int W0   = 5000;
  localparam int W1   = 10000;
  localparam int UNIT = QUAD ? 2 : 8;

  logic rst_n, req_valid, req_ready, req_write, rsp_valid, rsp_ready;
  logic tx_valid, tx_ready, rx_valid, rx_ready, init_done;
  logic [23:0] req_addr;
  logic [3:0]  req_len;
  logic [63:0] req_wdata, rsp_data;
  logic [7:0]  tx_byte, rx_byte;

  psram_req_ctrl #(.QUAD(QUAD)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_byte(rx_byte), .init_done(init_done));

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rx_got[$];
  int cyc = 0, popped = 0, t_end = 0, rx_k = 0, rd_len = 0;
  bit g0 = 0, g1 = 0, init_seen = 0, rd_pending = 0, stall = 0;
  logic [7:0] stall_byte;

  initial begin errs = 0; checks = 0; done = 0; end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void push_cmd(input logic [7:0] c, input string tag);
    exp_q.push_back(8'd8); exp_q.push_back(8'd0);
    repeat (2) tag_q.push_back(tag);
    if (QUAD) begin
      for (int k = 0; k < 4; k++) begin
        exp_q.push_back(((c >> (7 - 2*k)) & 8'h1) << 4 | ((c >> (6 - 2*k)) & 8'h1));
        tag_q.push_back("R4");
      end
    end else begin
      exp_q.push_back(c); tag_q.push_back(tag);
    end
  endfunction

  function automatic void push_req(input bit w, input logic [23:0] a,
                                   input logic [63:0] d, input int n, input string tag);
    logic [7:0] hdr[$];
    if (w) hdr = '{8'((4 + n) * UNIT), 8'd0, QUAD ? 8'h38 : 8'h02};
    else   hdr = '{QUAD ? 8'd10 : 8'd40, 8'(n * UNIT), QUAD ? 8'hEB : 8'h0B};
    hdr.push_back(a[23:16]); hdr.push_back(a[15:8]); hdr.push_back(a[7:0]);
    if (w) for (int i = 0; i < n; i++) hdr.push_back(d[8*i +: 8]);
    else   hdr.push_back(8'hFF);
    foreach (hdr[i]) begin exp_q.push_back(hdr[i]); tag_q.push_back(tag); end
  endfunction

  always @(posedge clk) cyc++;

  always @(posedge clk) begin
    #1;
    tx_ready = (cyc % 5 != 2);
    rx_valid = (cyc % 4 != 1);
    rx_byte  = 8'(rx_k * 37 + (QUAD ? 11 : 91));
  end

  // Reference model, compared every cycle
  always @(negedge clk) if (rst_n) begin
    chk(!(req_ready && (exp_q.size() != 0 || rd_pending)), "R8",
        "ready while busy", 64'(req_ready), 0);
    if (stall) chk(tx_valid && tx_byte == stall_byte, "R9", "byte moved under stall",
                   64'(tx_byte), 64'(stall_byte));
    chk(!rx_ready || (rd_pending && exp_q.size() == 0 && rx_got.size() < rd_len),
        "R11", "rx_ready out of window", 64'(rx_ready), 0);
    if (tx_valid && !g0 && popped == LEN0) begin
      g0 = 1;
      chk(cyc - t_end >= W0 && cyc - t_end <= W0 + 8, "R2", "first wait",
          64'(cyc - t_end), 64'(W0));
    end
    if (QUAD && tx_valid && !g1 && popped == 2*LEN0) begin
      g1 = 1;
      chk(cyc - t_end >= W1 && cyc - t_end <= W1 + 8, "R2", "second wait",
          64'(cyc - t_end), 64'(W1));
    end
    if (req_ready && !init_seen) begin
      init_seen = 1;
      chk(popped == (QUAD ? 3 : 2) * LEN0, "R3", "start-up byte count",
          64'(popped), 64'((QUAD ? 3 : 2) * LEN0));
      chk(init_done == 1'b1, "R3", "init_done", 64'(init_done), 1);
      if (!QUAD) chk(cyc - t_end >= W1, "R2", "wait before ready", 64'(cyc - t_end), 64'(W1));
    end
    if (tx_valid && tx_ready) begin
      if (exp_q.size() == 0) chk(0, "R5", "unexpected byte", 64'(tx_byte), 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(tx_byte == e, t, "frame byte", 64'(tx_byte), 64'(e));
      end
      popped++;
      if (popped == LEN0 || popped == 2*LEN0) t_end = cyc;
    end
    if (rx_valid && rx_ready) begin rx_got.push_back(rx_byte); rx_k++; end
    stall = tx_valid && !tx_ready;
    stall_byte = tx_byte;
  end

  task automatic do_req(input bit w, input logic [23:0] a, input logic [63:0] d,
                        input logic [3:0] len, input string tag);
    int n;
    n = (len == 0) ? 1 : (len > 8) ? 8 : int'(len);
    @(posedge clk); #1;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_len = len;
    forever begin @(negedge clk); if (req_ready) break; end
    @(posedge clk);
    push_req(w, a, d, n, tag);
    if (!w) begin rd_pending = 1; rd_len = n; end
    #1 req_valid = 0;
    if (w) begin
      forever begin @(negedge clk); if (exp_q.size() == 0) break; end
    end else begin
      logic [63:0] e;
      forever begin @(negedge clk); if (rsp_valid) break; end
      e = '0;
      for (int i = 0; i < n && i < rx_got.size(); i++) e[8*i +: 8] = rx_got[i];
      chk(rx_got.size() == n, "R11", "bytes consumed", 64'(rx_got.size()), 64'(n));
      chk(rsp_data == e, "R7", "read data", rsp_data, e);
      repeat (3) begin
        @(negedge clk);
        chk(rsp_valid && rsp_data == e, "R7", "result held", rsp_data, e);
      end
      @(posedge clk); #1 rsp_ready = 1;
      @(posedge clk); #1 rsp_ready = 0;
      rd_pending = 0;
      rx_got.delete();
    end
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_len = '0;
    req_wdata = '0; rsp_ready = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    push_cmd(8'h66, "R1");
    push_cmd(8'h99, "R2");
    if (QUAD) push_cmd(8'h35, "R3");
    @(negedge clk);
    chk(req_ready == 0 && init_done == 0, "R1", "reset state",
        {62'd0, req_ready, init_done}, 0);
    wait (init_seen);
    do_req(1, 24'h123456, 64'h00000000000000A5, 4'd1, "R5");
    do_req(1, 24'hABCDEF, 64'h000000000000BEEF, 4'd2, "R5");
    do_req(1, 24'h000102, 64'h00000000DEADC0DE, 4'd4, "R5");
    do_req(1, 24'hFFFFFF, 64'h0123456789ABCDEF, 4'd8, "R5");
    do_req(1, 24'h00A0B0, 64'h000000000000775A, 4'd0, "R10");
    do_req(1, 24'h3C3C3C, 64'hF0E1D2C3B4A59687, 4'd12, "R10");
    do_req(0, 24'h010203, 64'h0, 4'd1, "R6");
    do_req(0, 24'h7F0000, 64'h0, 4'd2, "R6");
    do_req(0, 24'h00FF00, 64'h0, 4'd4, "R6");
    do_req(0, 24'h800001, 64'h0, 4'd8, "R6");
    do_req(0, 24'h55AA55, 64'h0, 4'd3, "R6");
    repeat (10) @(posedge clk);
    done = 1;
  end
endmodule

module sim_psram_req_ctrl;
  logic clk = 0;
  always #5 clk = ~clk;

  int e_q, c_q, e_s, c_s;
  logic d_q, d_s;
  int cycles = 0;

  sim_lane #(.QUAD(1'b1)) lane_quad   (.clk(clk), .errs(e_q), .checks(c_q), .done(d_q));
  sim_lane #(.QUAD(1'b0)) lane_single (.clk(clk), .errs(e_s), .checks(c_s), .done(d_s));

  always @(posedge clk) cycles++;

  initial begin
    int errs, total;
    wait ((d_q && d_s) || cycles >= 200000);
    errs  = e_q + e_s;
    total = c_q + c_s;
    if (!(d_q && d_s)) begin
      errs++; total++;
      $display("FAIL watchdog expired actual=%0d expected<200000", cycles);
    end
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule